// File: doc/BRIEF.md
# Configurable Carry-Save Adder Row

This block is one row of carry-save cells for a radix-2 modular multiplier that keeps its running value as a pair of vectors, a partial sum and a partial carry. A single mode input chooses how every cell in the row behaves. In full-adder mode the row compresses three vectors (sum, carry and an addend) into a new sum and carry pair. In paired half-adder mode the same gates are regrouped into two half-adder stages in series. One pass then applies two carry-resolving half-adder steps to the sum and carry vectors and ignores the addend.

The multiplier uses full-adder mode inside its main loop. It uses paired half-adder mode for the operand pre-addition and for the final conversion from carry-save form to plain binary. In those phases the result is fed back to the row input every cycle until the carry vector is zero. Because two carry positions are resolved per pass, these phases need about half as many cycles. The row is combinational. A parameter selects whether its outputs are registered, which is the form a feedback loop needs.

All arithmetic wraps modulo 2^WIDTH, so a carry out of the top bit is discarded.

Top module: `cfg_csa_stage`

## Requirements
- R1: With fa_mode=1, each bit j of sum_o is the XOR of sum_i[j], carry_i[j] and addend_i[j]. carry_o[0] is 0, and carry_o[j+1] is the majority of those three bits.
- R2: With fa_mode=1, (sum_o + carry_o) mod 2^WIDTH equals (sum_i + carry_i + addend_i) mod 2^WIDTH.
- R3: With fa_mode=0, (sum_o, carry_o) equals two applications of the step (s, c) -> (s XOR c, (s AND c) shifted left by one) to (sum_i, carry_i).
- R4: With fa_mode=0, addend_i has no effect on sum_o or carry_o.
- R5: With fa_mode=0, (sum_o + carry_o) mod 2^WIDTH equals (sum_i + carry_i) mod 2^WIDTH.
- R6: With fa_mode=0, carry_o bits 1 and 0 are both 0.
- R7: When the outputs are fed back to the inputs with fa_mode=0, carry_o is zero after at most ceil(WIDTH/2)+1 passes, starting from any pair, including the worst case sum_i all ones with carry_i = 1. sum_o then holds (sum_i + carry_i) mod 2^WIDTH of the starting pair.
- R8: With REGISTERED=1, the outputs present the row result of the inputs sampled at the previous rising clock edge. While rst_n is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| fa_mode | input | 1 | 1: one three-input compression; 0: two chained half-adder steps |
| sum_i | input | WIDTH | Incoming partial-sum vector |
| carry_i | input | WIDTH | Incoming partial-carry vector |
| addend_i | input | WIDTH | Third operand, used only when fa_mode=1 |
| sum_o | output | WIDTH | New partial-sum vector |
| carry_o | output | WIDTH | New partial-carry vector |

## Verification
The hardest case is the all-ones sum with a single carry in bit 0. That carry must ripple the whole width. A row that forms the second half-adder from the wrong neighbour, or that resolves only one position per pass, converges too late or settles on the wrong binary value. The bench feeds the outputs back and counts the passes to a zero carry. It also drives the same sum and carry with different addends in paired half-adder mode, so an addend that leaks through the selector shows up as a changed result. In full-adder mode, random and all-ones vectors catch a majority that is shifted into the wrong bit or a top carry that is not dropped. Both mode changes and a reset in mid-run check that the register holds exactly one cycle of latency and clears to zero.

// File: rtl/ccsa_pkg.sv
package ccsa_pkg;

  typedef enum logic {
    CSA_PAIR_HA   = 1'b0,
    CSA_SINGLE_FA = 1'b1
  } csa_mode_e;

  // Per-bit generate term, shared with the next cell up in paired-HA mode.
  function automatic logic cell_gen(input logic s, input logic c);
    return s & c;
  endfunction

  // Reduced operand selector: the zero input of the addend choice is folded
  // away, leaving an AND-OR of the addend and the lower neighbour's generate.
  function automatic logic cell_operand(input logic a, input logic g_prev,
                                        input logic fa);
    return (a & fa) | (g_prev & ~fa);
  endfunction

  // Returns {carry, sum} for one configurable cell.
  function automatic logic [1:0] cell_eval(input logic s, input logic c,
                                           input logic t, input logic fa);
    logic p;
    logic g;
    p = s ^ c;
    g = s & c;
    return {(fa & g) | (p & t), p ^ t};
  endfunction

endpackage

// File: rtl/ccsa_cell.sv
module ccsa_cell
  import ccsa_pkg::*;
(
  input  logic s_i,
  input  logic c_i,
  input  logic a_i,
  input  logic g_prev_i,
  input  logic fa_i,
  output logic g_o,
  output logic sum_o,
  output logic cy_o
);

  logic       op_sel;
  logic [1:0] res;

  always_comb begin
    g_o    = cell_gen(s_i, c_i);
    op_sel = cell_operand(a_i, g_prev_i, fa_i);
    res    = cell_eval(s_i, c_i, op_sel, fa_i);
    sum_o  = res[0];
    cy_o   = res[1];
  end

endmodule

// File: rtl/ccsa_row.sv
module ccsa_row #(
  parameter int W = 16
) (
  input  logic         fa_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] gen;
  logic [W-1:0] cy;
  logic [W-1:0] g_prev;
  logic         row_unused_msb;

  assign g_prev = {gen[W-2:0], 1'b0};

  for (genvar j = 0; j < W; j++) begin : g_cell
    ccsa_cell u_cell (
      .s_i      (s_i[j]),
      .c_i      (c_i[j]),
      .a_i      (a_i[j]),
      .g_prev_i (g_prev[j]),
      .fa_i     (fa_i),
      .g_o      (gen[j]),
      .sum_o    (sum_o[j]),
      .cy_o     (cy[j])
    );
  end

  // Carry of the top cell leaves the word (modulo 2^W arithmetic).
  assign carry_o        = {cy[W-2:0], 1'b0};
  assign gen_o          = gen;
  assign row_unused_msb = cy[W-1];

endmodule

// File: rtl/ccsa_out_stage.sv
module ccsa_out_stage #(
  parameter int W   = 16,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sum_d,
  input  logic [W-1:0] carry_d,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] carry_q
);

  if (REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q   <= '0;
        carry_q <= '0;
      end else begin
        sum_q   <= sum_d;
        carry_q <= carry_d;
      end
    end
  end else begin : g_comb
    logic stage_unused;
    assign stage_unused = clk ^ rst_n;
    assign sum_q        = sum_d;
    assign carry_q      = carry_d;
  end

endmodule

// File: rtl/cfg_csa_stage.sv
module cfg_csa_stage
  import ccsa_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fa_mode,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic [WIDTH-1:0] addend_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);

  localparam int LSB_CLEAR = 2;

  csa_mode_e        mode;
  logic [WIDTH-1:0] row_sum;
  logic [WIDTH-1:0] row_carry;
  logic [WIDTH-1:0] row_gen;
  logic             row_unused_gen;

  assign mode           = csa_mode_e'(fa_mode);
  assign row_unused_gen = row_gen[WIDTH-1] ^ row_gen[LSB_CLEAR-1];

  ccsa_row #(.W(WIDTH)) u_row (
    .fa_i    (mode == CSA_SINGLE_FA),
    .s_i     (sum_i),
    .c_i     (carry_i),
    .a_i     (addend_i),
    .gen_o   (row_gen),
    .sum_o   (row_sum),
    .carry_o (row_carry)
  );

  ccsa_out_stage #(.W(WIDTH), .REG(REGISTERED)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_d   (row_sum),
    .carry_d (row_carry),
    .sum_q   (sum_o),
    .carry_q (carry_o)
  );

endmodule

// File: rtl/ccsa_chk.sv
module ccsa_chk #(
  parameter int W   = 16,
  parameter bit REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fa_mode,
  input logic [W-1:0] sum_i,
  input logic [W-1:0] carry_i,
  input logic [W-1:0] addend_i,
  input logic [W-1:0] row_sum,
  input logic [W-1:0] row_carry,
  input logic [W-1:0] sum_o,
  input logic [W-1:0] carry_o
);

  function automatic logic [W-1:0] two_step_sum(input logic [W-1:0] s,
                                                input logic [W-1:0] c);
    return s ^ c ^ ((s & c) << 1);
  endfunction

  function automatic logic [W-1:0] two_step_carry(input logic [W-1:0] s,
                                                  input logic [W-1:0] c);
    return ((s ^ c) & ((s & c) << 1)) << 1;
  endfunction

  function automatic logic [W-1:0] majority_up(input logic [W-1:0] s,
                                               input logic [W-1:0] c,
                                               input logic [W-1:0] a);
    return ((s & c) | (s & a) | (c & a)) << 1;
  endfunction

  // R1
  fa_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fa_mode |-> row_carry == majority_up(sum_i, carry_i, addend_i));

  // R2
  fa_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fa_mode |-> (W'(row_sum + row_carry) == W'(sum_i + carry_i + addend_i)));

  // R3
  ha_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fa_mode |-> (row_sum == two_step_sum(sum_i, carry_i) &&
                  row_carry == two_step_carry(sum_i, carry_i)));

  // R5
  ha_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fa_mode |-> (W'(row_sum + row_carry) == W'(sum_i + carry_i)));

  // R6
  ha_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fa_mode |-> row_carry[1:0] == 2'b00);

  if (REG) begin : g_reg_chk
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
    end

    // R8
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (sum_o == $past(row_sum) && carry_o == $past(row_carry)));

    // R8
    out_reset_chk: assert property (@(posedge clk)
      !rst_n |-> (sum_o == '0 && carry_o == '0));
  end else begin : g_comb_chk
    // R8
    out_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_o == row_sum && carry_o == row_carry);
  end

endmodule

bind cfg_csa_stage ccsa_chk #(.W(WIDTH), .REG(REGISTERED)) u_ccsa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fa_mode   (fa_mode),
  .sum_i     (sum_i),
  .carry_i   (carry_i),
  .addend_i  (addend_i),
  .row_sum   (row_sum),
  .row_carry (row_carry),
  .sum_o     (sum_o),
  .carry_o   (carry_o)
);

// File: tb/cfg_csa_stage_tb_top.sv
`timescale 1ns/1ps
module cfg_csa_stage_tb_top;

  localparam int W      = 16;
  localparam int CONV_N = (W + 1) / 2 + 1;
  typedef logic [W-1:0] vec_t;

  typedef struct {
    vec_t exp_s;
    vec_t exp_c;
    vec_t total;
    bit   half;
    int   req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fa_mode = 1'b1;
  vec_t sum_i = '0;
  vec_t carry_i = '0;
  vec_t addend_i = '0;
  vec_t sum_o;
  vec_t carry_o;

  int    n_checks = 0;
  int    n_fail = 0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  cfg_csa_stage #(.WIDTH(W), .REGISTERED(1'b1)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fa_mode  (fa_mode),
    .sum_i    (sum_i),
    .carry_i  (carry_i),
    .addend_i (addend_i),
    .sum_o    (sum_o),
    .carry_o  (carry_o)
  );

  task automatic check(input bit ok, input string req, input vec_t act,
                       input vec_t exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bitwise full-adder model: count ones per column.
  function automatic void model_full(input vec_t s, input vec_t c, input vec_t a,
                                     output vec_t so, output vec_t co);
    so = '0;
    co = '0;
    for (int j = 0; j < W; j++) begin
      int cnt;
      cnt   = int'(s[j]) + int'(c[j]) + int'(a[j]);
      so[j] = cnt[0];
      if (j < W - 1) co[j+1] = cnt[1];
    end
  endfunction

  function automatic void model_half(input vec_t s, input vec_t c,
                                     output vec_t so, output vec_t co);
    vec_t x;
    vec_t y;
    x = s;
    y = c;
    for (int k = 0; k < 2; k++) begin
      vec_t nx;
      nx = x ^ y;
      y  = (x & y) << 1;
      x  = nx;
    end
    so = x;
    co = y;
  endfunction

  // Driver: one vector per cycle, expected item queued for the monitor.
  task automatic drive(input bit fa, input vec_t s, input vec_t c, input vec_t a,
                       input int req);
    item_t it;
    @(negedge clk);
    fa_mode  = fa;
    sum_i    = s;
    carry_i  = c;
    addend_i = a;
    if (fa) begin
      model_full(s, c, a, it.exp_s, it.exp_c);
      it.total = s + c + a;
    end else begin
      model_half(s, c, it.exp_s, it.exp_c);
      it.total = s + c;
    end
    it.half = !fa;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  // Monitor: result of a vector appears after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.req == 1)
          check(sum_o == it.exp_s && carry_o == it.exp_c, "R1", sum_o ^ carry_o,
                it.exp_s ^ it.exp_c);
        else if (it.req == 4)
          check(sum_o == it.exp_s && carry_o == it.exp_c, "R4", sum_o, it.exp_s);
        else
          check(sum_o == it.exp_s && carry_o == it.exp_c, "R3", sum_o, it.exp_s);
        check(vec_t'(sum_o + carry_o) == it.total, it.half ? "R5" : "R2",
              vec_t'(sum_o + carry_o), it.total);
        if (it.half) check(carry_o[1:0] == 2'b00, "R6", carry_o, '0);
      end
    end
  end

  // R7: feed outputs back in paired-HA mode until the carry is gone.
  task automatic converge(input vec_t s0, input vec_t c0);
    int   passes;
    vec_t target;
    target = s0 + c0;
    passes = 0;
    @(negedge clk);
    fa_mode = 1'b0;
    sum_i   = s0;
    carry_i = c0;
    addend_i = 16'hBEEF;
    for (int n = 1; n <= CONV_N; n++) begin
      @(posedge clk);
      #2;
      if (passes == 0 && carry_o == '0) passes = n;
      @(negedge clk);
      sum_i   = sum_o;
      carry_i = carry_o;
    end
    check(passes != 0 && passes <= CONV_N, "R7", vec_t'(passes), vec_t'(CONV_N));
    check(sum_o == target && carry_o == '0, "R7", sum_o, target);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    vec_t r1;
    vec_t r2;
    vec_t r3;
    // R8: outputs held at zero in reset
    repeat (2) @(posedge clk);
    #2;
    check(sum_o == '0 && carry_o == '0, "R8", sum_o | carry_o, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: directed full-adder patterns
    drive(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1);
    drive(1'b1, 16'h0000, 16'h0000, 16'h0000, 1);
    drive(1'b1, 16'hAAAA, 16'h5555, 16'h0F0F, 1);
    drive(1'b1, 16'h8000, 16'h8000, 16'h0001, 1);
    for (int i = 0; i < 40; i++) begin
      r1 = vec_t'($urandom);
      r2 = vec_t'($urandom);
      r3 = vec_t'($urandom);
      drive(1'b1, r1, r2, r3, 1);
    end

    // R3/R5/R6: paired half-adder patterns, mode toggles in between
    drive(1'b0, 16'hFFFF, 16'h0001, 16'h0000, 3);
    drive(1'b1, 16'h1234, 16'h4321, 16'h00FF, 1);
    drive(1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 3);
    drive(1'b0, 16'h7FFF, 16'h7FFF, 16'h0000, 3);
    for (int i = 0; i < 40; i++) begin
      r1 = vec_t'($urandom);
      r2 = vec_t'($urandom);
      drive(1'b0, r1, r2, vec_t'($urandom), 3);
    end

    // R4: same sum/carry, different addends, identical expected result
    drive(1'b0, 16'h0F0F, 16'h00FF, 16'h0000, 4);
    drive(1'b0, 16'h0F0F, 16'h00FF, 16'hFFFF, 4);
    drive(1'b0, 16'h0F0F, 16'h00FF, 16'hA5A5, 4);
    repeat (3) @(posedge clk);

    // R7: worst-case chain and random pairs
    converge(16'hFFFF, 16'h0001);
    converge(16'h7FFF, 16'h0001);
    for (int i = 0; i < 6; i++) converge(vec_t'($urandom), vec_t'($urandom));

    // R8: reset in mid-run clears the register
    @(negedge clk);
    fa_mode = 1'b1;
    sum_i   = 16'hFFFF;
    carry_i = 16'hFFFF;
    addend_i = 16'hFFFF;
    @(posedge clk);
    #2;
    check(sum_o == 16'hFFFF && carry_o == 16'hFFFE, "R8", carry_o, 16'hFFFE);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sum_o == '0 && carry_o == '0, "R8", sum_o | carry_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(sum_o == 16'hFFFF && carry_o == 16'hFFFE, "R8", sum_o, 16'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule